// File: doc/BRIEF.md
# Service Request Node

This block is the per-source front end of an interrupt system. It keeps one pending flag for a single request source, together with that source's configuration: an enable bit, a service provider select and an 8-bit priority number. A peripheral raises the flag with a one-cycle hardware pulse. Software can also raise or drop the flag through command bits in the node's control word. These command bits act only at the moment of the write and are never stored.

Toward the arbiter, the node presents a request-valid signal together with its priority and its provider select. The arbiter grants a request by pulsing an acknowledge input and quoting the priority and provider it has granted. When that quote matches this node's own settings, the pending flag drops on the next clock. A priority of zero keeps the node silent: the request is never offered to the arbiter.

All state is registered. A write or a pulse on a clock edge appears on the read data and the request outputs from that edge onward. The read data is a combinational view of the stored state.

Top module: `srn_node`

## Requirements
- R1: After reset, every bit of the read data is 0, req_valid is 0, req_prio is 0 and req_prov is 0.
- R2: The control word has this layout:
  - bit 13 holds the pending flag;
  - bit 12 holds the enable bit;
  - bit 10 holds the low provider-select bit;
  - bits 7:0 hold the priority.

  A write stores bits 12, 10 and 7:0. Writing bit 13 does not change the pending flag. Bits 31:16, bits 9:8 and bit 11 always read 0, and writes to them are ignored.
- R3: A write with bit 15 = 1 and bit 14 = 0 sets the pending flag from the next clock onward.
- R4: A write with bit 14 = 1 and bit 15 = 0 clears the pending flag from the next clock onward, unless a hardware request arrives in the same cycle.
- R5: A write with both bit 15 and bit 14 = 1 leaves the pending flag unchanged. Bits 15 and 14 always read back as 0.
- R6: The provider select is two bits wide: 00 routes the request to the CPU and 01 routes it to the coprocessor. The upper bit (bit 11) is read-only and always 0.
- R7: A cycle with hw_req = 1 sets the pending flag from the next clock onward. This takes precedence over a software clear and over an acknowledge in the same cycle.
- R8: req_valid is 1 exactly when three conditions hold: the pending flag is 1, the enable bit is 1, and the priority is nonzero. A priority of 0x00 is never offered.
- R9: req_prio always equals the stored priority. req_prov always equals the stored provider select, with its upper bit 0.
- R10: An acknowledge clears the pending flag on the next clock only when ack_prio equals the stored priority and ack_prov equals the stored provider select. Any other acknowledge leaves the flag unchanged. A software set in the same cycle takes precedence over the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read view |
| hw_req | input | 1 | Hardware request pulse from the source |
| ack | input | 1 | Acknowledge pulse from the arbiter |
| ack_prio | input | 8 | Priority the arbiter granted |
| ack_prov | input | 2 | Provider the arbiter granted |
| req_valid | output | 1 | Request offered for arbitration |
| req_prio | output | 8 | Offered priority |
| req_prov | output | 2 | Offered provider select |

## Verification
The bench covers each of the following cases and the fault it would expose:
- Set and clear written together, with the flag both low and high beforehand. A design that let either command win would flip the flag.
- A hardware pulse in the same cycle as a software clear. Giving the clear priority would lose the interrupt.
- Acknowledges that miss on priority alone or on provider alone. A design that ignored either field would drop another node's request.
- Writes that put ones in reserved bits, in the read-only provider bit and in the pending bit. A careless design would store them or show them in the read data.
- A pending, enabled node with priority zero. A design that forgot this gating would raise a request that can never be serviced.

// File: rtl/srn_pkg.sv
package srn_pkg;
    // Control word field positions; bits 15:14 are commands, 13 the flag
    localparam int CMD_SET_BIT  = 15;
    localparam int CMD_CLR_BIT  = 14;
    localparam int PEND_BIT     = 13;
    localparam int EN_BIT       = 12;
    localparam int PROV_HI_BIT  = 11;
    localparam int PROV_LO_BIT  = 10;
    localparam int PRIO_LSB     = 0;
    localparam int CTRL_MIN_W   = 16;

    typedef struct packed {
        logic sw_set;
        logic sw_clr;
        logic cfg_wr;
    } cmd_t;
endpackage

// File: rtl/srn_cmd_decode.sv
module srn_cmd_decode
    import srn_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_t              cmd
);
    always_comb begin
        cmd.cfg_wr = wr_en;
        // set and clear written together cancel each other
        cmd.sw_set = wr_en &  wr_data[CMD_SET_BIT] & ~wr_data[CMD_CLR_BIT];
        cmd.sw_clr = wr_en &  wr_data[CMD_CLR_BIT] & ~wr_data[CMD_SET_BIT];
    end
endmodule

// File: rtl/srn_cfg.sv
module srn_cfg #(
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              en_in,
    input  logic              prov_in,
    input  logic [PRIO_W-1:0] prio_in,
    output logic              en_q,
    output logic              prov_q,
    output logic [PRIO_W-1:0] prio_q
);
    typedef struct packed {
        logic              en;
        logic              prov;
        logic [PRIO_W-1:0] prio;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d.en   = en_in;
            cfg_d.prov = prov_in;
            cfg_d.prio = prio_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_q   = cfg_q.en;
    assign prov_q = cfg_q.prov;
    assign prio_q = cfg_q.prio;

    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (prio_q == $past(prio_in)) && (en_q == $past(en_in)));
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(prio_q) && $stable(en_q) && $stable(prov_q));
endmodule

// File: rtl/srn_pend.sv
module srn_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic hw_req,
    input  logic ack_hit,
    output logic pend
);
    typedef struct packed {
        logic pend;
    } pend_s;

    pend_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hw_req)       st_d.pend = 1'b1;
        else if (sw_set)  st_d.pend = 1'b1;
        else if (sw_clr)  st_d.pend = 1'b0;
        else if (ack_hit) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    assert_hw_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_req |=> pend);
    assert_sw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set |=> pend);
    assert_sw_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !hw_req) |=> !pend);
    assert_ack_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !hw_req && !sw_set) |=> !pend);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_req && !sw_set && !sw_clr && !ack_hit) |=> $stable(pend));
endmodule

// File: rtl/srn_node.sv
module srn_node
    import srn_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              hw_req,
    input  logic              ack,
    input  logic [PRIO_W-1:0] ack_prio,
    input  logic [1:0]        ack_prov,
    output logic              req_valid,
    output logic [PRIO_W-1:0] req_prio,
    output logic [1:0]        req_prov
);
    localparam int PRIO_MSB = PRIO_LSB + PRIO_W - 1;

    cmd_t              cmd;
    logic              en_q;
    logic              prov_q;
    logic [PRIO_W-1:0] prio_q;
    logic              pend_q;
    logic              ack_hit;

    srn_cmd_decode #(.DATA_W(DATA_W)) u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    srn_cfg #(.PRIO_W(PRIO_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cmd.cfg_wr),
        .en_in   (wr_data[EN_BIT]),
        .prov_in (wr_data[PROV_LO_BIT]),
        .prio_in (wr_data[PRIO_MSB:PRIO_LSB]),
        .en_q    (en_q),
        .prov_q  (prov_q),
        .prio_q  (prio_q)
    );

    always_comb begin
        ack_hit = ack && (ack_prio == prio_q) && (ack_prov == {1'b0, prov_q});
    end

    srn_pend u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_set  (cmd.sw_set),
        .sw_clr  (cmd.sw_clr),
        .hw_req  (hw_req),
        .ack_hit (ack_hit),
        .pend    (pend_q)
    );

    always_comb begin
        rd_data                      = '0;
        rd_data[PEND_BIT]            = pend_q;
        rd_data[EN_BIT]              = en_q;
        rd_data[PROV_LO_BIT]         = prov_q;
        rd_data[PRIO_MSB:PRIO_LSB]   = prio_q;
        req_prio                     = prio_q;
        req_prov                     = {1'b0, prov_q};
        req_valid                    = pend_q && en_q && (prio_q != '0);
    end

    assert_valid_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (rd_data[PRIO_MSB:PRIO_LSB] != '0) && rd_data[PEND_BIT]);
    assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CMD_SET_BIT] && wr_data[CMD_CLR_BIT] && !hw_req && !ack_hit)
        |=> $stable(rd_data[PEND_BIT]));
    assert_ack_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (ack_prio != req_prio) && !wr_en && !hw_req) |=> $stable(req_valid));
    assert_hw_win_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_req && wr_en && wr_data[CMD_CLR_BIT]) |=> rd_data[PEND_BIT]);
endmodule

// File: tb/srn_node_test.sv
`timescale 1ns/100ps
module srn_node_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        hw_req;
    logic        ack;
    logic [7:0]  ack_prio;
    logic [1:0]  ack_prov;
    logic        req_valid;
    logic [7:0]  req_prio;
    logic [1:0]  req_prov;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // behavioural reference state
    bit       m_pend, m_en, m_prov;
    bit [7:0] m_prio;

    always #2.5 clk = ~clk;

    srn_node uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .hw_req(hw_req), .ack(ack), .ack_prio(ack_prio),
        .ack_prov(ack_prov), .req_valid(req_valid), .req_prio(req_prio),
        .req_prov(req_prov)
    );

    task automatic compare(input string tag);
        logic [31:0] e_rd;
        logic        e_v;
        e_rd = 32'h0;
        e_rd[13] = m_pend;
        e_rd[12] = m_en;
        e_rd[10] = m_prov;
        e_rd[7:0] = m_prio;
        e_v = m_pend && m_en && (m_prio != 0);
        vectors++;
        if (rd_data !== e_rd || req_valid !== e_v || req_prio !== m_prio ||
            req_prov !== {1'b0, m_prov}) begin
            miscompares++;
            $display("FAIL %s rd=%h/%h valid=%b/%b prio=%h/%h prov=%b/%b (actual/expected)",
                     tag, rd_data, e_rd, req_valid, e_v, req_prio, m_prio,
                     req_prov, {1'b0, m_prov});
        end
    endtask

    task automatic step(input logic w, input logic [31:0] d, input logic h,
                        input logic a, input logic [7:0] ap, input logic [1:0] av,
                        input string tag);
        bit hit;
        wr_en = w; wr_data = d; hw_req = h; ack = a; ack_prio = ap; ack_prov = av;
        @(posedge clk);
        hit = a && (ap == m_prio) && (av == {1'b0, m_prov});
        if (h)                       m_pend = 1;
        else if (w && d[15] && !d[14]) m_pend = 1;
        else if (w && d[14] && !d[15]) m_pend = 0;
        else if (hit)                m_pend = 0;
        if (w) begin
            m_en = d[12]; m_prov = d[10]; m_prio = d[7:0];
        end
        @(negedge clk);
        wr_en = 0; wr_data = 0; hw_req = 0; ack = 0; ack_prio = 0; ack_prov = 0;
        compare(tag);
    endtask

    task automatic wr(input logic [31:0] d, input string tag);
        step(1, d, 0, 0, 8'h0, 2'b00, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 32'h0, 0, 0, 8'h0, 2'b00, tag);
    endtask

    initial begin
        rst_n = 0; wr_en = 0; wr_data = 0; hw_req = 0; ack = 0;
        ack_prio = 0; ack_prov = 0;
        m_pend = 0; m_en = 0; m_prov = 0; m_prio = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        compare("R1 reset");
        idle("R1 idle");
        // reserved, read-only and flag bits ignored
        wr(32'hFFFF_3B05, "R2 layout, R6 bit11 read-only");
        idle("R9 hold");
        wr(32'h0000_9005, "R3 software set");
        idle("R8 valid");
        step(0, 0, 0, 1, 8'h06, 2'b00, "R10 ack prio miss");
        step(0, 0, 0, 1, 8'h05, 2'b01, "R10 ack prov miss");
        step(0, 0, 0, 1, 8'h05, 2'b00, "R10 ack match");
        step(0, 0, 1, 0, 8'h00, 2'b00, "R7 hardware set");
        wr(32'h0000_5005, "R4 software clear");
        wr(32'h0000_D005, "R5 cancel with flag low");
        step(0, 0, 1, 0, 8'h00, 2'b00, "R7 hardware set again");
        wr(32'h0000_D005, "R5 cancel with flag high");
        step(1, 32'h0000_5005, 1, 0, 8'h00, 2'b00, "R7 hw beats sw clear");
        step(1, 32'h0000_9005, 0, 1, 8'h05, 2'b00, "R10 set beats ack");
        wr(32'h0000_1000, "R8 priority zero never valid");
        wr(32'h0000_0007, "R8 disabled not valid");
        wr(32'h0000_1407, "R6 coprocessor route");
        step(0, 0, 0, 1, 8'h07, 2'b00, "R10 provider mismatch");
        step(0, 0, 0, 1, 8'h07, 2'b01, "R10 coprocessor ack");
        wr(32'h0000_1CFF, "R9 top priority, R6 bit11 ignored");
        step(0, 0, 1, 1, 8'hFF, 2'b01, "R7 hw beats ack");
        step(0, 0, 0, 1, 8'hFF, 2'b01, "R10 ack clears");
        wr(32'h0000_C0FF, "R5 command bits read zero");
        idle("R9 final");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule